// File: doc/BRIEF.md
# Integer Execute Unit for a 32-bit RISC Pipeline

This block is the arithmetic and logic stage of a 32-bit load/store integer pipeline. It is purely combinational. The decode stage hands it a primary opcode, a function code, a shift amount, the two register operand values and the raw 16-bit immediate. In the same cycle the unit returns a 32-bit result, a flag that asks for an arithmetic-overflow trap, and a flag for an encoding it does not implement. The pipeline registers on either side belong to the surrounding stages.

Inside, a decoder turns the opcode and function code into an internal operation, an operand source (register or immediate), an extension rule and a trap enable. An operand stage builds the second operand and the upper-immediate value. A datapath computes the result and the overflow condition. The opcode decides the extension rule. Arithmetic and compare immediates copy bit 15 upward. The two logical immediates fill the upper half with zeros. The unsigned compare against an immediate extends the immediate with its sign first and then compares the two values without sign. The block has no states.

Top module: `risc_exec_unit`

## Requirements
- R1: With opcode 0x00, function codes 0x20 and 0x21 give rs_val+rt_val, and 0x22 and 0x23 give rs_val−rt_val, each modulo 2^32.
- R2: With opcode 0x00, function 0x24 gives rs_val AND rt_val, 0x25 gives OR, and 0x27 gives the bitwise inverse of the OR.
- R3: overflow is 1 only for function 0x20 (add), function 0x22 (subtract) and opcode 0x08 (add immediate), and only when the signed result does not fit in 32 bits. Functions 0x21 and 0x23 and opcode 0x09 never set it and give the same bit result.
- R4: Function 0x2A and opcode 0x0A (against the sign-extended immediate) give 1 when the first operand is less than the second as two's complement numbers, else 0. Bits 31:1 are zero.
- R5: Function 0x2B compares rs_val with rt_val as unsigned numbers. Opcode 0x0B sign-extends the immediate and then compares without sign. The result is 1 or 0 in bit 0.
- R6: Functions 0x00, 0x02 and 0x03 shift rt_val left logically, right logically and right arithmetically by shamt. rs_val has no effect on them.
- R7: Opcodes 0x08 and 0x09 add the sign-extended immediate to rs_val. Opcodes 0x0C and 0x0D AND and OR rs_val with the zero-extended immediate.
- R8: Opcode 0x0F returns the immediate in bits 31:16 with bits 15:0 zero.
- R9: Any other opcode, or opcode 0x00 with any other function code, gives illegal=1, result=0 and overflow=0. Every implemented encoding gives illegal=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode of the instruction |
| funct | input | 6 | Function code, used when opcode is 0x00 |
| shamt | input | 5 | Constant shift amount |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand, also the shift source |
| imm | input | 16 | Raw immediate field |
| result | output | 32 | Computed result |
| overflow | output | 1 | Request for an arithmetic-overflow trap |
| illegal | output | 1 | Encoding not implemented by this unit |

## Verification
The hardest case to reach is the one where the trapping and non-trapping forms differ only in the flag. Random operands rarely land on the sign boundary. The stimulus table drives add, addu, sub, subu, addi and addiu with operands placed exactly at 0x7FFFFFFF and 0x80000000, so each pair gives the same result bits while only one raises the flag. The unsigned immediate compare is driven with an immediate of 0xFFFF, because only that kind of value shows whether the immediate was sign-extended before the unsigned compare. A reference-model loop then covers every supported encoding with random operands.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        XOP_NONE,
        XOP_ADD,
        XOP_SUB,
        XOP_AND,
        XOP_OR,
        XOP_NOR,
        XOP_SLT,
        XOP_SLTU,
        XOP_SLL,
        XOP_SRL,
        XOP_SRA,
        XOP_LUI
    } xop_e;

    typedef struct packed {
        xop_e op;
        logic use_imm;
        logic imm_zext;
        logic trap_en;
        logic illegal;
    } xctrl_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import exec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output xctrl_t           ctrl
);

    always_comb begin
        ctrl = '{op: XOP_NONE, use_imm: 1'b0, imm_zext: 1'b0,
                 trap_en: 1'b0, illegal: 1'b0};
        unique case (opcode)
            OPC_RTYPE: begin
                unique case (funct)
                    FN_ADD:  begin ctrl.op = XOP_ADD; ctrl.trap_en = 1'b1; end
                    FN_ADDU: ctrl.op = XOP_ADD;
                    FN_SUB:  begin ctrl.op = XOP_SUB; ctrl.trap_en = 1'b1; end
                    FN_SUBU: ctrl.op = XOP_SUB;
                    FN_AND:  ctrl.op = XOP_AND;
                    FN_OR:   ctrl.op = XOP_OR;
                    FN_NOR:  ctrl.op = XOP_NOR;
                    FN_SLT:  ctrl.op = XOP_SLT;
                    FN_SLTU: ctrl.op = XOP_SLTU;
                    FN_SLL:  ctrl.op = XOP_SLL;
                    FN_SRL:  ctrl.op = XOP_SRL;
                    FN_SRA:  ctrl.op = XOP_SRA;
                    default: ctrl.illegal = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                ctrl.op = XOP_ADD; ctrl.use_imm = 1'b1; ctrl.trap_en = 1'b1;
            end
            OPC_ADDIU: begin ctrl.op = XOP_ADD;  ctrl.use_imm = 1'b1; end
            OPC_SLTI:  begin ctrl.op = XOP_SLT;  ctrl.use_imm = 1'b1; end
            OPC_SLTIU: begin ctrl.op = XOP_SLTU; ctrl.use_imm = 1'b1; end
            OPC_ANDI: begin
                ctrl.op = XOP_AND; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
            end
            OPC_ORI: begin
                ctrl.op = XOP_OR; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1;
            end
            OPC_LUI:  ctrl.op = XOP_LUI;
            default:  ctrl.illegal = 1'b1;
        endcase
    end

    // R3
    always_comb begin
        trap_only_arith_chk: assert (!ctrl.trap_en ||
            (ctrl.op == XOP_ADD || ctrl.op == XOP_SUB))
            else $error("trap enable on a non-arithmetic op");
    end

endmodule

// File: rtl/exec_operand.sv
module exec_operand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              imm_zext,
    output logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] upper_val
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic             fill_bit;
    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        fill_bit  = imm_zext ? 1'b0 : imm[IMM_W-1];
        imm_ext   = {{EXT_W{fill_bit}}, imm};
        opnd_b    = use_imm ? imm_ext : rt_val;
        upper_val = {imm, {EXT_W{1'b0}}};
    end

    // R7
    always_comb begin
        zext_upper_chk: assert (!(use_imm && imm_zext) ||
            opnd_b[DATA_W-1:IMM_W] == '0)
            else $error("logical immediate not zero-extended");
    end

endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
    import exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xop_e              op,
    input  logic              trap_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] shift_src,
    input  logic [$clog2(DATA_W)-1:0] shift_amt,
    input  logic [DATA_W-1:0] upper_val,
    output logic [DATA_W-1:0] result,
    output logic              overflow
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum_v;
    logic [DATA_W-1:0] diff_v;
    logic              add_ovf;
    logic              sub_ovf;

    always_comb begin
        sum_v   = opnd_a + opnd_b;
        diff_v  = opnd_a - opnd_b;
        add_ovf = (opnd_a[MSB] == opnd_b[MSB]) && (sum_v[MSB] != opnd_a[MSB]);
        sub_ovf = (opnd_a[MSB] != opnd_b[MSB]) && (diff_v[MSB] != opnd_a[MSB]);
    end

    always_comb begin
        result   = '0;
        overflow = 1'b0;
        unique case (op)
            XOP_ADD: begin result = sum_v;  overflow = trap_en && add_ovf; end
            XOP_SUB: begin result = diff_v; overflow = trap_en && sub_ovf; end
            XOP_AND:  result = opnd_a & opnd_b;
            XOP_OR:   result = opnd_a | opnd_b;
            XOP_NOR:  result = ~(opnd_a | opnd_b);
            XOP_SLT:  result = {{MSB{1'b0}}, ($signed(opnd_a) < $signed(opnd_b))};
            XOP_SLTU: result = {{MSB{1'b0}}, (opnd_a < opnd_b)};
            XOP_SLL:  result = shift_src << shift_amt;
            XOP_SRL:  result = shift_src >> shift_amt;
            XOP_SRA:  result = DATA_W'($signed(shift_src) >>> shift_amt);
            XOP_LUI:  result = upper_val;
            default:  result = '0;
        endcase
    end

    // R4
    always_comb begin
        set_flag_width_chk: assert (!(op == XOP_SLT || op == XOP_SLTU) ||
            result[DATA_W-1:1] == '0)
            else $error("compare result wider than one bit");
    end

    // R8
    always_comb begin
        upper_low_zero_chk: assert (op != XOP_LUI || result[DATA_W/2-1:0] == '0)
            else $error("upper-immediate low half not zero");
    end

endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FN_W-1:0]   funct,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              overflow,
    output logic              illegal
);

    xctrl_t            ctrl;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] upper_val;

    exec_decode u_decode (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    exec_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
        .rt_val    (rt_val),
        .imm       (imm),
        .use_imm   (ctrl.use_imm),
        .imm_zext  (ctrl.imm_zext),
        .opnd_b    (opnd_b),
        .upper_val (upper_val)
    );

    exec_datapath #(.DATA_W(DATA_W)) u_datapath (
        .op        (ctrl.op),
        .trap_en   (ctrl.trap_en),
        .opnd_a    (rs_val),
        .opnd_b    (opnd_b),
        .shift_src (rt_val),
        .shift_amt (shamt),
        .upper_val (upper_val),
        .result    (result),
        .overflow  (overflow)
    );

    assign illegal = ctrl.illegal;

    // R3
    always_comb begin
        no_overflow_chk: assert (!overflow ||
            (opcode == OPC_ADDI) ||
            (opcode == OPC_RTYPE && (funct == FN_ADD || funct == FN_SUB)))
            else $error("overflow raised by a non-trapping encoding");
    end

    // R9
    always_comb begin
        illegal_quiet_chk: assert (!illegal || (result == '0 && !overflow))
            else $error("illegal encoding produced a result or trap");
    end

endmodule

// File: tb/test_risc_exec_unit.sv
module test_risc_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        overflow;
    logic        illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    risc_exec_unit i_risc_exec_unit (
        .opcode   (opcode),
        .funct    (funct),
        .shamt    (shamt),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm      (imm),
        .result   (result),
        .overflow (overflow),
        .illegal  (illegal)
    );

    typedef struct packed {
        logic [5:0]  opc;
        logic [5:0]  fn;
        logic [4:0]  sh;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] im;
        logic [31:0] exp_res;
        logic        exp_ovf;
        logic        exp_ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 6'h20, 5'd0, 32'd5,        32'd7,        16'h0000, 32'd12,       1'b0, 1'b0, 4'd1}, // R1
        '{6'h00, 6'h20, 5'd0, 32'h7FFFFFFF, 32'd1,        16'h0000, 32'h80000000, 1'b1, 1'b0, 4'd3}, // R3
        '{6'h00, 6'h21, 5'd0, 32'h7FFFFFFF, 32'd1,        16'h0000, 32'h80000000, 1'b0, 1'b0, 4'd3}, // R3
        '{6'h00, 6'h22, 5'd0, 32'h80000000, 32'd1,        16'h0000, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd3}, // R3
        '{6'h00, 6'h23, 5'd0, 32'h80000000, 32'd1,        16'h0000, 32'h7FFFFFFF, 1'b0, 1'b0, 4'd3}, // R3
        '{6'h00, 6'h22, 5'd0, 32'd10,       32'd3,        16'h0000, 32'd7,        1'b0, 1'b0, 4'd1}, // R1
        '{6'h00, 6'h20, 5'd0, 32'h80000000, 32'h80000000, 16'h0000, 32'h00000000, 1'b1, 1'b0, 4'd3}, // R3
        '{6'h00, 6'h24, 5'd0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hF000F000, 1'b0, 1'b0, 4'd2}, // R2
        '{6'h00, 6'h25, 5'd0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hFFF0FFF0, 1'b0, 1'b0, 4'd2}, // R2
        '{6'h00, 6'h27, 5'd0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'h000F000F, 1'b0, 1'b0, 4'd2}, // R2
        '{6'h00, 6'h2A, 5'd0, 32'hFFFFFFFF, 32'd1,        16'h0000, 32'd1,        1'b0, 1'b0, 4'd4}, // R4
        '{6'h00, 6'h2B, 5'd0, 32'hFFFFFFFF, 32'd1,        16'h0000, 32'd0,        1'b0, 1'b0, 4'd5}, // R5
        '{6'h00, 6'h2A, 5'd0, 32'd5,        32'd5,        16'h0000, 32'd0,        1'b0, 1'b0, 4'd4}, // R4
        '{6'h00, 6'h00, 5'd4, 32'hDEADBEEF, 32'd3,        16'h0000, 32'h00000030, 1'b0, 1'b0, 4'd6}, // R6
        '{6'h00, 6'h02, 5'd31,32'hDEADBEEF, 32'h80000000, 16'h0000, 32'd1,        1'b0, 1'b0, 4'd6}, // R6
        '{6'h00, 6'h03, 5'd4, 32'h12345678, 32'h80000000, 16'h0000, 32'hF8000000, 1'b0, 1'b0, 4'd6}, // R6
        '{6'h08, 6'h00, 5'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0001, 32'h80000000, 1'b1, 1'b0, 4'd3}, // R3
        '{6'h08, 6'h00, 5'd0, 32'd10,       32'h0,        16'hFFFF, 32'd9,        1'b0, 1'b0, 4'd7}, // R7
        '{6'h09, 6'h00, 5'd0, 32'h7FFFFFFF, 32'h0,        16'h0001, 32'h80000000, 1'b0, 1'b0, 4'd3}, // R3
        '{6'h0A, 6'h00, 5'd0, 32'hFFFFFFFE, 32'h0,        16'hFFFF, 32'd1,        1'b0, 1'b0, 4'd4}, // R4
        '{6'h0B, 6'h00, 5'd0, 32'd5,        32'h0,        16'hFFFF, 32'd1,        1'b0, 1'b0, 4'd5}, // R5
        '{6'h0B, 6'h00, 5'd0, 32'hFFFFFFFF, 32'h0,        16'hFFFF, 32'd0,        1'b0, 1'b0, 4'd5}, // R5
        '{6'h0C, 6'h00, 5'd0, 32'hFFFFFFFF, 32'h0,        16'h8001, 32'h00008001, 1'b0, 1'b0, 4'd7}, // R7
        '{6'h0D, 6'h00, 5'd0, 32'h12340000, 32'h0,        16'h8000, 32'h12348000, 1'b0, 1'b0, 4'd7}, // R7
        '{6'h0F, 6'h00, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 32'hABCD0000, 1'b0, 1'b0, 4'd8}, // R8
        '{6'h04, 6'h00, 5'd0, 32'd1,        32'd1,        16'h0004, 32'd0,        1'b0, 1'b1, 4'd9}, // R9
        '{6'h00, 6'h26, 5'd0, 32'h0F0F0F0F, 32'hFFFFFFFF, 16'h0000, 32'd0,        1'b0, 1'b1, 4'd9}, // R9
        '{6'h00, 6'h18, 5'd0, 32'h7FFFFFFF, 32'd1,        16'h0000, 32'd0,        1'b0, 1'b1, 4'd9}  // R9
    };

    // Behavioural reference: returns {illegal, overflow, result}
    function automatic logic [33:0] ref_model(input logic [5:0] opc, input logic [5:0] fn,
                                              input logic [4:0] sh, input logic [31:0] a,
                                              input logic [31:0] b, input logic [15:0] im);
        logic [31:0] sx = {{16{im[15]}}, im};
        logic [31:0] zx = {16'h0000, im};
        longint s;
        logic [31:0] r = '0;
        logic ov = 1'b0;
        logic il = 1'b0;
        case (opc)
            6'h00: case (fn)
                6'h20: begin s = longint'($signed(a)) + longint'($signed(b)); r = a + b;
                             ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
                6'h21: r = a + b;
                6'h22: begin s = longint'($signed(a)) - longint'($signed(b)); r = a - b;
                             ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
                6'h23: r = a - b;
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h27: r = ~(a | b);
                6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'h2B: r = (a < b) ? 32'd1 : 32'd0;
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                6'h03: r = $unsigned($signed(b) >>> sh);
                default: il = 1'b1;
            endcase
            6'h08: begin s = longint'($signed(a)) + longint'($signed(sx)); r = a + sx;
                         ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            6'h09: r = a + sx;
            6'h0A: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            6'h0B: r = (a < sx) ? 32'd1 : 32'd0;
            6'h0C: r = a & zx;
            6'h0D: r = a | zx;
            6'h0F: r = {im, 16'h0000};
            default: il = 1'b1;
        endcase
        return {il, ov, r};
    endfunction

    task automatic chk(input int req, input logic [31:0] er, input logic eo, input logic ei);
        checks++;
        if (result !== er || overflow !== eo || illegal !== ei) begin
            failures++;
            $display("FAIL R%0d op=%h fn=%h: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
                     req, opcode, funct, result, overflow, illegal, er, eo, ei);
        end
    endtask

    task automatic apply(input logic [5:0] opc, input logic [5:0] fn, input logic [4:0] sh,
                         input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
        @(negedge clk);
        opcode = opc; funct = fn; shamt = sh; rs_val = a; rt_val = b; imm = im;
        @(posedge clk);
        #2;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    localparam logic [5:0] ROPC [19] = '{6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,
                                         6'h00,6'h00,6'h00,6'h08,6'h09,6'h0A,6'h0B,6'h0C,6'h0D,6'h0F};
    localparam logic [5:0] RFN  [19] = '{6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h27,6'h2A,6'h2B,
                                         6'h00,6'h02,6'h03,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [33:0] exp_v;
        // Idle inputs during reset decode as a zero-amount left shift of zero (R6)
        repeat (3) @(posedge clk);
        #2;
        chk(6, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].opc, VECS[i].fn, VECS[i].sh, VECS[i].a, VECS[i].b, VECS[i].im);
            chk(int'(VECS[i].req), VECS[i].exp_res, VECS[i].exp_ovf, VECS[i].exp_ill);
        end

        // R6: rs_val has no effect on a shift
        apply(6'h00, 6'h03, 5'd8, 32'h00000000, 32'h8765_4321, 16'h0);
        chk(6, 32'hFF876543, 1'b0, 1'b0);
        apply(6'h00, 6'h03, 5'd8, 32'hFFFFFFFF, 32'h8765_4321, 16'h0);
        chk(6, 32'hFF876543, 1'b0, 1'b0);

        // R5: sltiu with small immediate, unsigned vs large rs
        apply(6'h0B, 6'h00, 5'd0, 32'h80000000, 32'h0, 16'h7FFF);
        chk(5, 32'd0, 1'b0, 1'b0);

        // R9: unused opcode with trapping-looking operands stays quiet
        apply(6'h3F, 6'h20, 5'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h7FFF);
        chk(9, 32'd0, 1'b0, 1'b1);

        // Random operands over every supported encoding (R1, R2, R3, R4, R5, R6, R7, R8)
        for (int k = 0; k < 400; k++) begin
            int idx = int'($urandom % 19);
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            logic [15:0] ri = 16'($urandom);
            logic [4:0]  rsh = 5'($urandom);
            if (k % 4 == 0) ra = {ra[31], 31'h7FFFFFF0} ^ {28'h0, ra[3:0]};
            apply(ROPC[idx], RFN[idx], rsh, ra, rb, ri);
            exp_v = ref_model(ROPC[idx], RFN[idx], rsh, ra, rb, ri);
            chk(ROPC[idx] == 6'h0F ? 8 : (ROPC[idx] == 6'h00 ? 1 : 7),
                exp_v[31:0], exp_v[32], exp_v[33]);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule